// File: doc/BRIEF.md
# Frequency Profile Playback Interpolator

This block holds a time-dependent carrier frequency profile and turns it into a running frequency-correction word for a downstream oscillator. A host loads the profile as a byte stream during an upload session. The stream starts with a 64-bit start time and continues with 32-bit signed frequency samples. Every multi-byte field is sent most significant byte first. Each sample is in units of the 125 MHz processing clock divided by 2^32, which is about 29 mHz per LSB. Samples are one second apart.

A 64-bit receiver time in 250 ps units is compared with the stored start time. Once the receiver time has reached the start time, the block walks through the table. It splits every one-second interval into 64 equal steps, so the correction never jumps. Each step is the difference between neighbouring samples, arithmetically shifted right by 6. The steps are added at 1/64-second intervals, which a prescaler on the processing clock produces. At each segment boundary the value is reloaded exactly from the next sample.

The block adds the interpolated value to a fixed signed nominal offset. It reports each new step with a one-cycle strobe. Playback does not depend on any lock status, and it runs only once per uploaded table. Opening a new upload session stops it at once.

Top module: `fprof_player`

## Requirements
- R1: While reset is asserted, `freq_out` is 0 and `freq_valid` and `play_active` are low.
- R2: After `up_open`, the first 8 bytes with `up_valid` form the start time, most significant byte first. Every following group of 4 bytes forms one sample, most significant byte first. A table is usable only when all 8 header bytes arrived before `up_close`.
- R3: With a usable table of at least two samples and no session open, `play_active` rises in the cycle after unsigned `rx_time >= start time` is first seen. It stays low while `rx_time` is below the start time. The first strobe comes TICKS_PER_STEP cycles after `play_active` rises.
- R4: Strobes are exactly TICKS_PER_STEP cycles apart. Segment j produces 64 strobes. Strobe k of segment j carries `nom_ofs + s[j] + k*d`, where d is the 33-bit difference `s[j+1]-s[j]` arithmetically shifted right by 6 and truncated to 32 bits. All sums wrap modulo 2^32.
- R5: After strobe 63 of the segment that starts at the second-to-last sample, `play_active` falls and `freq_out` equals `nom_ofs`. The table does not play again.
- R6: With no usable table, or a table of fewer than two samples, no strobe occurs, `play_active` stays low and `freq_out` follows `nom_ofs`.
- R7: Bytes of an incomplete trailing sample are discarded at `up_close`. The whole samples received before it form the table.
- R8: `up_open` during playback suppresses any strobe on that edge. It drops `play_active` in the next cycle and returns `freq_out` to `nom_ofs` one cycle later.
- R9: While an upload session is open, playback never starts, even when `rx_time` is past the start time.
- R10: When not playing, `freq_out` equals the value of `nom_ofs` one cycle earlier.
- R11: Samples beyond DEPTH in one upload are ignored. The first DEPTH samples play.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_open | input | 1 | Pulse: start an upload session; aborts playback |
| up_close | input | 1 | Pulse: end the upload session |
| up_valid | input | 1 | `up_data` carries a byte this cycle |
| up_data | input | 8 | Upload byte |
| rx_time | input | TIME_W (64) | Receiver time, 250 ps units |
| nom_ofs | input | SAMPLE_W (32) | Fixed signed nominal frequency offset |
| freq_out | output | SAMPLE_W (32) | Nominal offset plus interpolated profile |
| freq_valid | output | 1 | One-cycle strobe per interpolation step |
| play_active | output | 1 | Profile playback in progress |

## Verification
The bench builds the block with DEPTH = 8 and TICKS_PER_STEP = 8, which makes a simulated second only 512 cycles long. Full multi-segment playbacks, the exact strobe spacing and the capacity limit (a ten-sample upload) all fit in a few thousand cycles. The small depth brings the over-capacity path within reach. The short step window still leaves room for the two-read prefetch before each step. A nominal offset near the positive limit makes the sum wrap.

// File: rtl/fprof_pkg.sv
package fprof_pkg;

   // Read/prefetch phase of the playback sequencer
   typedef enum logic [2:0] {
      FP_IDLE,
      FP_RD0,
      FP_LD0,
      FP_RDN,
      FP_CALC
   } fetch_ph_t;

   // Minimum clock cycles per step needed to finish a segment prefetch
   localparam int unsigned MIN_TICKS = 8;

endpackage

// File: rtl/fprof_loader.sv
module fprof_loader #(
   parameter int unsigned DEPTH    = 4096,
   parameter int unsigned SAMPLE_W = 32,
   parameter int unsigned TIME_W   = 64,
   localparam int unsigned AW      = $clog2(DEPTH),
   localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                up_open,
   input  logic                up_close,
   input  logic                up_valid,
   input  logic [7:0]          up_data,
   output logic                uploading,
   output logic                table_ok,
   output logic [TIME_W-1:0]   start_time,
   output logic [CW-1:0]       n_samples,
   output logic                we,
   output logic [AW-1:0]       waddr,
   output logic [SAMPLE_W-1:0] wdata
);

   localparam int unsigned HB  = TIME_W / 8;
   localparam int unsigned SB  = SAMPLE_W / 8;
   localparam int unsigned HCW = $clog2(HB + 1);
   localparam int unsigned BCW = $clog2(SB);

   logic [HCW-1:0]      hdr_cnt;
   logic [BCW-1:0]      bsel;
   logic [SAMPLE_W-1:0] word;
   logic                hdr_done;
   logic [SAMPLE_W-1:0] word_next;

   assign hdr_done  = (hdr_cnt == HCW'(HB));
   assign word_next = {word[SAMPLE_W-9:0], up_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uploading  <= 1'b0;
         table_ok   <= 1'b0;
         start_time <= '0;
         n_samples  <= '0;
         hdr_cnt    <= '0;
         bsel       <= '0;
         word       <= '0;
         we         <= 1'b0;
         waddr      <= '0;
         wdata      <= '0;
      end else begin
         we <= 1'b0;
         if (up_open) begin
            uploading <= 1'b1;
            table_ok  <= 1'b0;
            hdr_cnt   <= '0;
            bsel      <= '0;
            n_samples <= '0;
         end else if (uploading) begin
            if (up_close) begin
               uploading <= 1'b0;
               table_ok  <= hdr_done;
            end else if (up_valid) begin
               if (!hdr_done) begin
                  start_time <= {start_time[TIME_W-9:0], up_data};
                  hdr_cnt    <= hdr_cnt + HCW'(1);
               end else begin
                  word <= word_next;
                  bsel <= bsel + BCW'(1);
                  if (bsel == BCW'(SB - 1)) begin
                     bsel <= '0;
                     if (n_samples != CW'(DEPTH)) begin
                        we        <= 1'b1;
                        waddr     <= n_samples[AW-1:0];
                        wdata     <= word_next;
                        n_samples <= n_samples + CW'(1);
                     end
                  end
               end
            end
         end
      end
   end

   // R2: the sample memory is written only inside an upload session
   a_r2_write_in_session: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> uploading);

   // R11: the stored sample count never passes the memory depth
   a_r11_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (n_samples == CW'(DEPTH)) && !up_open |=> (n_samples == CW'(DEPTH)) || !uploading);

endmodule

// File: rtl/fprof_store.sv
module fprof_store #(
   parameter int unsigned DEPTH = 4096,
   parameter int unsigned W     = 32,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
      if (re) begin
         rdata <= mem[raddr];
      end
   end

endmodule

// File: rtl/fprof_sequencer.sv
module fprof_sequencer
   import fprof_pkg::*;
#(
   parameter int unsigned DEPTH          = 4096,
   parameter int unsigned SAMPLE_W       = 32,
   parameter int unsigned TIME_W         = 64,
   parameter int unsigned TICKS_PER_STEP = 1953125,
   parameter int unsigned STEP_LOG2      = 6,
   localparam int unsigned AW            = $clog2(DEPTH),
   localparam int unsigned CW            = $clog2(DEPTH + 1),
   localparam int unsigned PW            = $clog2(TICKS_PER_STEP),
   localparam int unsigned KW            = STEP_LOG2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                abort,
   input  logic                uploading,
   input  logic                table_ok,
   input  logic [TIME_W-1:0]   start_time,
   input  logic [CW-1:0]       n_samples,
   input  logic [TIME_W-1:0]   rx_time,
   input  logic [SAMPLE_W-1:0] rdata,
   output logic                re,
   output logic [AW-1:0]       raddr,
   output logic                prof_on,
   output logic [SAMPLE_W-1:0] prof_val,
   output logic                tick
);

   logic                       play;
   logic                       done;
   logic [PW-1:0]              pre;
   logic [KW-1:0]              k;
   logic [CW-1:0]              seg;
   logic [SAMPLE_W-1:0]        acc;
   logic [SAMPLE_W-1:0]        step;
   logic [SAMPLE_W-1:0]        nxt;
   fetch_ph_t                  fph;
   logic signed [SAMPLE_W:0]   diff;
   logic                       last_k;
   logic                       last_seg;
   logic                       armed;

   assign tick     = play && (pre == PW'(TICKS_PER_STEP - 1));
   assign last_k   = (k == KW'((1 << STEP_LOG2) - 1));
   assign last_seg = ((seg + CW'(2)) >= n_samples);
   assign armed    = !done && table_ok && !uploading;
   assign diff     = $signed({rdata[SAMPLE_W-1], rdata}) - $signed({acc[SAMPLE_W-1], acc});

   assign re       = (fph == FP_RD0) || (fph == FP_RDN);
   assign raddr    = (fph == FP_RD0) ? '0 : AW'(seg + CW'(1));
   assign prof_on  = play;
   assign prof_val = acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         play <= 1'b0;
         done <= 1'b0;
         pre  <= '0;
         k    <= '0;
         seg  <= '0;
         acc  <= '0;
         step <= '0;
         nxt  <= '0;
         fph  <= FP_IDLE;
      end else if (abort) begin
         play <= 1'b0;
         done <= 1'b0;
         fph  <= FP_IDLE;
      end else if (!play) begin
         if (armed && (rx_time >= start_time)) begin
            if (n_samples >= CW'(2)) begin
               play <= 1'b1;
               pre  <= '0;
               k    <= '0;
               seg  <= '0;
               acc  <= '0;
               fph  <= FP_RD0;
            end else begin
               done <= 1'b1;
            end
         end
      end else begin
         pre <= tick ? '0 : pre + PW'(1);
         case (fph)
            FP_RD0:  fph <= FP_LD0;
            FP_LD0:  begin
               acc <= rdata;
               fph <= FP_RDN;
            end
            FP_RDN:  fph <= FP_CALC;
            FP_CALC: begin
               nxt  <= rdata;
               step <= SAMPLE_W'(diff >>> STEP_LOG2);
               fph  <= FP_IDLE;
            end
            default: ;
         endcase
         if (tick) begin
            if (last_k) begin
               if (last_seg) begin
                  play <= 1'b0;
                  done <= 1'b1;
               end else begin
                  acc <= nxt;
                  seg <= seg + CW'(1);
                  k   <= '0;
                  fph <= FP_RDN;
               end
            end else begin
               acc <= acc + step;
               k   <= k + KW'(1);
            end
         end
      end
   end

   // R3: playback only begins after the receiver time reached the start time
   a_r3_start_on_time: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(play) |-> $past(rx_time >= start_time));

   // R5: the current segment always has a following sample in the table
   a_r5_segment_in_table: assert property (@(posedge clk) disable iff (!rst_n)
      play |-> ((seg + CW'(1)) < n_samples));

   // R4: the prefetch has finished before any step is taken
   a_r4_prefetch_ready: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (fph == FP_IDLE));

endmodule

// File: rtl/fprof_player.sv
module fprof_player #(
   parameter int unsigned DEPTH          = 4096,
   parameter int unsigned SAMPLE_W       = 32,
   parameter int unsigned TIME_W         = 64,
   parameter int unsigned TICKS_PER_STEP = 1953125,
   parameter int unsigned STEP_LOG2      = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                up_open,
   input  logic                up_close,
   input  logic                up_valid,
   input  logic [7:0]          up_data,
   input  logic [TIME_W-1:0]   rx_time,
   input  logic [SAMPLE_W-1:0] nom_ofs,
   output logic [SAMPLE_W-1:0] freq_out,
   output logic                freq_valid,
   output logic                play_active
);

   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   generate
      if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if ((SAMPLE_W < 16) || ((SAMPLE_W % 8) != 0) || ((SAMPLE_W / 8) & (SAMPLE_W / 8 - 1)) != 0) begin : g_bad_sample
         $error("SAMPLE_W must be 16, 32 or 64 style byte multiple");
      end
      if ((TIME_W < 16) || ((TIME_W % 8) != 0)) begin : g_bad_time
         $error("TIME_W must be a whole number of bytes");
      end
      if (TICKS_PER_STEP < fprof_pkg::MIN_TICKS) begin : g_bad_ticks
         $error("TICKS_PER_STEP too small for the segment prefetch");
      end
      if ((STEP_LOG2 < 1) || (STEP_LOG2 > 16)) begin : g_bad_steps
         $error("STEP_LOG2 out of range");
      end
   endgenerate

   logic                uploading;
   logic                table_ok;
   logic [TIME_W-1:0]   start_time;
   logic [CW-1:0]       n_samples;
   logic                we;
   logic [AW-1:0]       waddr;
   logic [SAMPLE_W-1:0] wdata;
   logic                re;
   logic [AW-1:0]       raddr;
   logic [SAMPLE_W-1:0] rdata;
   logic                prof_on;
   logic [SAMPLE_W-1:0] prof_val;
   logic                tick;

   fprof_loader #(
      .DEPTH    (DEPTH),
      .SAMPLE_W (SAMPLE_W),
      .TIME_W   (TIME_W)
   ) u_loader (
      .clk        (clk),
      .rst_n      (rst_n),
      .up_open    (up_open),
      .up_close   (up_close),
      .up_valid   (up_valid),
      .up_data    (up_data),
      .uploading  (uploading),
      .table_ok   (table_ok),
      .start_time (start_time),
      .n_samples  (n_samples),
      .we         (we),
      .waddr      (waddr),
      .wdata      (wdata)
   );

   fprof_store #(
      .DEPTH (DEPTH),
      .W     (SAMPLE_W)
   ) u_store (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .re    (re),
      .raddr (raddr),
      .rdata (rdata)
   );

   fprof_sequencer #(
      .DEPTH          (DEPTH),
      .SAMPLE_W       (SAMPLE_W),
      .TIME_W         (TIME_W),
      .TICKS_PER_STEP (TICKS_PER_STEP),
      .STEP_LOG2      (STEP_LOG2)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .abort      (up_open),
      .uploading  (uploading),
      .table_ok   (table_ok),
      .start_time (start_time),
      .n_samples  (n_samples),
      .rx_time    (rx_time),
      .rdata      (rdata),
      .re         (re),
      .raddr      (raddr),
      .prof_on    (prof_on),
      .prof_val   (prof_val),
      .tick       (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         freq_out   <= '0;
         freq_valid <= 1'b0;
      end else begin
         freq_out   <= nom_ofs + (prof_on ? prof_val : '0);
         freq_valid <= tick && !up_open;
      end
   end

   assign play_active = prof_on;

   // R10: outside playback the output follows the nominal offset
   a_r10_idle_nominal: assert property (@(posedge clk) disable iff (!rst_n)
      !prof_on |=> (freq_out == $past(nom_ofs)));

   // R9: an open upload session and playback never overlap
   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      uploading |-> !prof_on);

   // R8: a new session stops playback on the next cycle
   a_r8_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
      up_open |=> !play_active);

   // R4: strobes are isolated single-cycle pulses
   a_r4_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
      freq_valid |=> !freq_valid);

endmodule

// File: tb/fprof_player_test.sv
module fprof_player_test;

   localparam int unsigned DEPTH = 8;
   localparam int unsigned TPS   = 8;
   localparam int unsigned SL2   = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        up_open = 1'b0;
   logic        up_close = 1'b0;
   logic        up_valid = 1'b0;
   logic [7:0]  up_data = '0;
   logic [63:0] rx_time = '0;
   logic [31:0] nom_ofs = '0;
   logic [31:0] freq_out;
   logic        freq_valid;
   logic        play_active;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   int last_evt = 0;
   int popped   = 0;
   logic prev_play = 1'b0;
   logic [31:0] sb [$];
   logic [31:0] tab [16];

   fprof_player #(
      .DEPTH          (DEPTH),
      .SAMPLE_W       (32),
      .TIME_W         (64),
      .TICKS_PER_STEP (TPS),
      .STEP_LOG2      (SL2)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .up_open     (up_open),
      .up_close    (up_close),
      .up_valid    (up_valid),
      .up_data     (up_data),
      .rx_time     (rx_time),
      .nom_ofs     (nom_ofs),
      .freq_out    (freq_out),
      .freq_valid  (freq_valid),
      .play_active (play_active)
   );

   always #10 clk = ~clk;

   task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
         summary();
         $finish;
      end
   end

   // Monitor: pops scoreboard entries on each strobe (R3, R4)
   always @(negedge clk) begin
      if (rst_n) begin
         if (play_active && !prev_play) last_evt = cyc;
         prev_play = play_active;
         if (freq_valid) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R4 unexpected strobe", {32'd0, freq_out}, 64'd0);
            end else begin
               logic [31:0] e;
               e = sb.pop_front();
               chk(freq_out == e, "R4 step value", {32'd0, freq_out}, {32'd0, e});
               chk((cyc - last_evt) == TPS, "R3 R4 strobe spacing",
                   64'(cyc - last_evt), 64'(TPS));
               popped++;
            end
            last_evt = cyc;
         end
      end
   end

   // Driver side of the scoreboard: expected strobes for tab[0..n-1]
   task automatic expect_table(input int n);
      for (int j = 0; j < n - 1; j++) begin
         logic signed [32:0] d;
         logic [31:0] v;
         d = $signed({tab[j+1][31], tab[j+1]}) - $signed({tab[j][31], tab[j]});
         d = d >>> SL2;
         v = tab[j];
         for (int k = 0; k < (1 << SL2); k++) begin
            sb.push_back(nom_ofs + v);
            v = v + d[31:0];
         end
      end
   endtask

   task automatic up_begin(input logic [63:0] st);
      @(negedge clk);
      up_open = 1'b1;
      @(negedge clk);
      up_open = 1'b0;
      for (int b = 7; b >= 0; b--) begin
         up_valid = 1'b1;
         up_data  = st[b*8 +: 8];
         @(negedge clk);
      end
      up_valid = 1'b0;
   endtask

   task automatic up_word(input logic [31:0] w);
      for (int b = 3; b >= 0; b--) begin
         up_valid = 1'b1;
         up_data  = w[b*8 +: 8];
         @(negedge clk);
      end
      up_valid = 1'b0;
   endtask

   task automatic up_end();
      up_close = 1'b1;
      @(negedge clk);
      up_close = 1'b0;
   endtask

   task automatic wait_done();
      wait (sb.size() == 0);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(freq_out == 32'd0, "R1 freq_out in reset", {32'd0, freq_out}, 64'd0);
      chk(freq_valid == 1'b0, "R1 freq_valid in reset", {63'd0, freq_valid}, 64'd0);
      chk(play_active == 1'b0, "R1 play_active in reset", {63'd0, play_active}, 64'd0);
      rst_n = 1'b1;

      // R6, R10: no table, output follows the nominal offset
      nom_ofs = 32'h0000_1234;
      rx_time = '1;
      repeat (2) @(negedge clk);
      chk(freq_out == nom_ofs, "R10 idle nominal", {32'd0, freq_out}, {32'd0, nom_ofs});
      repeat (20) @(negedge clk);
      chk(play_active == 1'b0, "R6 no table no play", {63'd0, play_active}, 64'd0);
      nom_ofs = 32'hCAFE_0001;
      @(negedge clk);
      chk(freq_out == 32'hCAFE_0001, "R10 nominal one cycle later", {32'd0, freq_out}, 64'hCAFE_0001);

      // R2, R3, R4, R5: three-sample table with byte-ordered start time
      rx_time = '0;
      tab[0] = 32'd100000; tab[1] = 32'd100640; tab[2] = 32'd99000;
      up_begin(64'h0102_0304_0506_0708);
      up_word(tab[0]); up_word(tab[1]); up_word(tab[2]);
      up_end();
      rx_time = 64'h0102_0304_0506_0707;
      repeat (30) @(negedge clk);
      chk(play_active == 1'b0, "R3 R2 no start before time", {63'd0, play_active}, 64'd0);
      expect_table(3);
      rx_time = 64'h0102_0304_0506_0708;
      wait_done();
      chk(play_active == 1'b0, "R5 stops after last segment", {63'd0, play_active}, 64'd0);
      chk(freq_out == nom_ofs, "R5 nominal after end", {32'd0, freq_out}, {32'd0, nom_ofs});
      repeat (600) @(negedge clk);
      chk(play_active == 1'b0, "R5 no replay", {63'd0, play_active}, 64'd0);

      // R8: new session aborts playback
      nom_ofs = 32'hFFFF_FFFB;
      rx_time = 64'd0;
      tab[0] = -32'sd2000; tab[1] = 32'd3000; tab[2] = 32'd7000; tab[3] = -32'sd100;
      up_begin(64'd50);
      up_word(tab[0]); up_word(tab[1]); up_word(tab[2]); up_word(tab[3]);
      up_end();
      expect_table(4);
      begin
         int base;
         base = popped;
         rx_time = 64'd100;
         wait (popped == base + 70);
      end
      @(negedge clk);
      up_open = 1'b1;
      sb.delete();
      @(negedge clk);
      up_open = 1'b0;
      chk(play_active == 1'b0, "R8 play stops next cycle", {63'd0, play_active}, 64'd0);
      @(negedge clk);
      chk(freq_out == nom_ofs, "R8 nominal after abort", {32'd0, freq_out}, {32'd0, nom_ofs});
      repeat (100) @(negedge clk);
      up_end();
      repeat (50) @(negedge clk);
      chk(play_active == 1'b0, "R6 empty session no play", {63'd0, play_active}, 64'd0);

      // R6: single-sample table never plays
      rx_time = 64'd1000;
      tab[0] = 32'd777;
      up_begin(64'd10);
      up_word(tab[0]);
      up_end();
      repeat (100) @(negedge clk);
      chk(play_active == 1'b0, "R6 single sample no play", {63'd0, play_active}, 64'd0);
      chk(freq_out == nom_ofs, "R6 single sample nominal", {32'd0, freq_out}, {32'd0, nom_ofs});

      // R7, R9: partial trailing sample dropped, no play while session open
      tab[0] = 32'h0001_0000; tab[1] = 32'h0000_FC00;
      up_begin(64'd5);
      up_word(tab[0]); up_word(tab[1]);
      up_valid = 1'b1; up_data = 8'h7F; @(negedge clk);
      up_valid = 1'b1; up_data = 8'h11; @(negedge clk);
      up_valid = 1'b0;
      repeat (50) @(negedge clk);
      chk(play_active == 1'b0, "R9 no play during session", {63'd0, play_active}, 64'd0);
      expect_table(2);
      up_end();
      wait_done();
      chk(play_active == 1'b0, "R7 two-sample table ends", {63'd0, play_active}, 64'd0);

      // R11, R4 wrap: ten samples into an eight-deep table
      nom_ofs = 32'h7FFF_FF00;
      rx_time = 64'd0;
      for (int i = 0; i < 10; i++) tab[i] = 32'(i) * 32'h80;
      up_begin(64'd20);
      for (int i = 0; i < 10; i++) up_word(tab[i]);
      up_end();
      expect_table(DEPTH);
      rx_time = 64'd20;
      wait_done();
      chk(play_active == 1'b0, "R11 stops at capacity", {63'd0, play_active}, 64'd0);
      chk(freq_out == nom_ofs, "R11 nominal after end", {32'd0, freq_out}, {32'd0, nom_ofs});
      chk(popped == 70 + 128 + 64 + 64 * (DEPTH - 1), "R11 strobe total", 64'(popped),
          64'(70 + 128 + 64 + 64 * (DEPTH - 1)));

      summary();
      $finish;
   end

endmodule